// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block decides, for a bridge between an upstream and a downstream bus, whether a transaction seen on the upstream side is claimed and passed downstream. It reads the bridge's base and limit configuration fields, which are stored elsewhere and arrive as static inputs. From those fields it rebuilds three forwarding windows: one I/O window, one non-prefetchable memory window and one prefetchable memory window. It also claims three fixed legacy display ranges when the display-forwarding control bit is set.

Each cycle the caller presents an address, a space flag (I/O or memory) and a valid strobe. One clock later the block reports a hit flag for each window class and a combined forward flag. Every comparison is inclusive at both ends. A window whose upper edge lies below its lower edge matches nothing.

Top module: `bridge_window_decode`

## Requirements
- R1: While `rst_n` is low, every output (`hit_valid`, `hit_io`, `hit_mem`, `hit_pf`, `hit_vga`, `forward`) is 0.
- R2: Outputs reflect the request presented on the previous rising clock edge. `hit_valid` equals the previous `req_valid`, and all hit flags and `forward` are 0 when the previous `req_valid` was 0.
- R3: The I/O window lower edge is `io_base[7:4]` placed at address bits 15:12 with bits 11:0 zero. The upper edge is `io_limit[7:4]` at bits 15:12 with bits 11:0 all ones. Both edges are inclusive. `hit_io` needs `req_is_io`=1.
- R4: Bit 0 of `io_base` (and, separately, of `io_limit`) set to 1 selects 32-bit I/O decoding. `io_base_upper` (resp. `io_limit_upper`) then supplies address bits 31:16 of that edge. Otherwise those bits are 0. Address bits 63:32 of every I/O window edge are 0.
- R5: The memory window lower edge is `mem_base[15:4]` at address bits 31:20 with bits 19:0 zero. The upper edge is `mem_limit[15:4]` at bits 31:20 with bits 19:0 all ones. Bits 3:0 of both fields have no effect. `hit_mem` needs `req_is_io`=0.
- R6: The prefetchable window is built like the memory window from `pf_base`/`pf_limit`. When bit 0 of `pf_base` (resp. `pf_limit`) is 1, `pf_base_upper` (resp. `pf_limit_upper`) supplies address bits 63:32 of that edge. Otherwise those bits are 0. `hit_pf` needs `req_is_io`=0.
- R7: `hit_io` is 0 whenever `io_space_en` was 0. `hit_mem` and `hit_pf` are 0 whenever `mem_space_en` was 0.
- R8: A window whose upper edge is numerically below its lower edge never hits.
- R9: With `vga_en`=1, `hit_vga` is 1 for memory addresses 0xA0000–0xBFFFF and for I/O addresses 0x3B0–0x3BB and 0x3C0–0x3DF. This is independent of `io_space_en` and `mem_space_en`. With `vga_en`=0, `hit_vga` is 0.
- R10: `forward` is the OR of `hit_io`, `hit_mem`, `hit_pf` and `hit_vga`.
- R11: I/O requests never raise memory hits, and memory requests never raise I/O hits. This holds for the legacy ranges too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request address is valid this cycle |
| req_addr | input | 64 | Transaction address |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| io_base | input | 8 | I/O base field: [7:4] address bits 15:12, [0] 32-bit select |
| io_limit | input | 8 | I/O limit field, same layout |
| io_base_upper | input | 16 | I/O base address bits 31:16 |
| io_limit_upper | input | 16 | I/O limit address bits 31:16 |
| mem_base | input | 16 | Memory base field: [15:4] address bits 31:20 |
| mem_limit | input | 16 | Memory limit field, same layout |
| pf_base | input | 16 | Prefetchable base: [15:4] bits 31:20, [0] 64-bit select |
| pf_limit | input | 16 | Prefetchable limit, same layout |
| pf_base_upper | input | 32 | Prefetchable base address bits 63:32 |
| pf_limit_upper | input | 32 | Prefetchable limit address bits 63:32 |
| io_space_en | input | 1 | Enables decoding of the I/O window |
| mem_space_en | input | 1 | Enables decoding of both memory windows |
| vga_en | input | 1 | Enables the legacy display ranges |
| hit_valid | output | 1 | Registered copy of req_valid |
| hit_io | output | 1 | I/O window hit |
| hit_mem | output | 1 | Memory window hit |
| hit_pf | output | 1 | Prefetchable window hit |
| hit_vga | output | 1 | Legacy display range hit |
| forward | output | 1 | Any hit: forward downstream |

## Verification
The bench probes each window one address below, at, and one above both edges. A decoder that compares exclusively, or that forgets the forced ones on the limit, loses the last 4 KiB or 1 MiB of a window and fails there.

The type bits are flipped independently on base and limit. A design that shares one type bit, or that ignores the upper registers, places an edge in the wrong 64 KiB or 4 GiB region.

Configurations with the limit below the base catch a decoder that wraps or takes an absolute difference. The legacy ranges are probed with the command enables cleared and with an alias above 4 GiB. This exposes any gating of those ranges by the command enables, and any decode that looks at truncated address bits.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int ADDR_W      = 64;
  localparam int IO_GRAN     = 12;
  localparam int IO_FIELD_W  = 4;
  localparam int IO_EXT_W    = 16;
  localparam int MEM_GRAN    = 20;
  localparam int MEM_FIELD_W = 12;
  localparam int PF_EXT_W    = 32;
  localparam int IO_BYTE_W   = 8;
  localparam int MEM_WORD_W  = 16;
  localparam int NUM_WIN     = 6;

  localparam logic [ADDR_W-1:0] LEG_MEM_LO   = 64'h000A_0000;
  localparam logic [ADDR_W-1:0] LEG_MEM_HI   = 64'h000B_FFFF;
  localparam logic [ADDR_W-1:0] LEG_IOA_LO   = 64'h0000_03B0;
  localparam logic [ADDR_W-1:0] LEG_IOA_HI   = 64'h0000_03BB;
  localparam logic [ADDR_W-1:0] LEG_IOB_LO   = 64'h0000_03C0;
  localparam logic [ADDR_W-1:0] LEG_IOB_HI   = 64'h0000_03DF;

  typedef enum logic [2:0] {
    WIN_IO, WIN_MEM, WIN_PF, WIN_LEG_MEM, WIN_LEG_IOA, WIN_LEG_IOB
  } win_e;

  typedef struct packed {
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
    logic              en;
    logic              io_space;
  } win_t;
endpackage

// File: rtl/bwd_edge_build.sv
module bwd_edge_build
  import bwd_pkg::*;
#(
  parameter int GRAN      = 12,
  parameter int FIELD_W   = 4,
  parameter int EXT_W     = 16,
  parameter bit FILL_ONES = 1'b0
) (
  input  logic [FIELD_W-1:0] field,
  input  logic               ext_sel,
  input  logic [EXT_W-1:0]   ext,
  output logic [ADDR_W-1:0]  edge_addr
);
  localparam int EXT_POS = GRAN + FIELD_W;

  always_comb begin
    edge_addr = '0;
    edge_addr[GRAN-1:0] = FILL_ONES ? {GRAN{1'b1}} : {GRAN{1'b0}};
    edge_addr[EXT_POS-1:GRAN] = field;
    if (ext_sel) edge_addr[EXT_POS +: EXT_W] = ext;
  end
endmodule

// File: rtl/bwd_range_match.sv
module bwd_range_match
  import bwd_pkg::*;
(
  input  win_t              win,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_io,
  output logic              match
);
  logic above_lo, below_hi;

  always_comb begin
    above_lo = (addr >= win.lo);
    below_hi = (addr <= win.hi);
    match    = win.en && (is_io == win.io_space) && above_lo && below_hi;
  end
endmodule

// File: rtl/bridge_window_decode.sv
module bridge_window_decode
  import bwd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   req_is_io,
  input  logic [IO_BYTE_W-1:0]   io_base,
  input  logic [IO_BYTE_W-1:0]   io_limit,
  input  logic [IO_EXT_W-1:0]    io_base_upper,
  input  logic [IO_EXT_W-1:0]    io_limit_upper,
  input  logic [MEM_WORD_W-1:0]  mem_base,
  input  logic [MEM_WORD_W-1:0]  mem_limit,
  input  logic [MEM_WORD_W-1:0]  pf_base,
  input  logic [MEM_WORD_W-1:0]  pf_limit,
  input  logic [PF_EXT_W-1:0]    pf_base_upper,
  input  logic [PF_EXT_W-1:0]    pf_limit_upper,
  input  logic                   io_space_en,
  input  logic                   mem_space_en,
  input  logic                   vga_en,
  output logic                   hit_valid,
  output logic                   hit_io,
  output logic                   hit_mem,
  output logic                   hit_pf,
  output logic                   hit_vga,
  output logic                   forward
);
  logic [ADDR_W-1:0] io_lo, io_hi, mem_lo, mem_hi, pf_lo, pf_hi;
  win_t              wins  [NUM_WIN];
  logic [NUM_WIN-1:0] match;

  bwd_edge_build #(.GRAN(IO_GRAN), .FIELD_W(IO_FIELD_W), .EXT_W(IO_EXT_W), .FILL_ONES(1'b0))
    u_io_lo (.field(io_base[IO_BYTE_W-1 -: IO_FIELD_W]), .ext_sel(io_base[0]),
             .ext(io_base_upper), .edge_addr(io_lo));
  bwd_edge_build #(.GRAN(IO_GRAN), .FIELD_W(IO_FIELD_W), .EXT_W(IO_EXT_W), .FILL_ONES(1'b1))
    u_io_hi (.field(io_limit[IO_BYTE_W-1 -: IO_FIELD_W]), .ext_sel(io_limit[0]),
             .ext(io_limit_upper), .edge_addr(io_hi));
  bwd_edge_build #(.GRAN(MEM_GRAN), .FIELD_W(MEM_FIELD_W), .EXT_W(PF_EXT_W), .FILL_ONES(1'b0))
    u_mem_lo (.field(mem_base[MEM_WORD_W-1 -: MEM_FIELD_W]), .ext_sel(1'b0),
              .ext('0), .edge_addr(mem_lo));
  bwd_edge_build #(.GRAN(MEM_GRAN), .FIELD_W(MEM_FIELD_W), .EXT_W(PF_EXT_W), .FILL_ONES(1'b1))
    u_mem_hi (.field(mem_limit[MEM_WORD_W-1 -: MEM_FIELD_W]), .ext_sel(1'b0),
              .ext('0), .edge_addr(mem_hi));
  bwd_edge_build #(.GRAN(MEM_GRAN), .FIELD_W(MEM_FIELD_W), .EXT_W(PF_EXT_W), .FILL_ONES(1'b0))
    u_pf_lo (.field(pf_base[MEM_WORD_W-1 -: MEM_FIELD_W]), .ext_sel(pf_base[0]),
             .ext(pf_base_upper), .edge_addr(pf_lo));
  bwd_edge_build #(.GRAN(MEM_GRAN), .FIELD_W(MEM_FIELD_W), .EXT_W(PF_EXT_W), .FILL_ONES(1'b1))
    u_pf_hi (.field(pf_limit[MEM_WORD_W-1 -: MEM_FIELD_W]), .ext_sel(pf_limit[0]),
             .ext(pf_limit_upper), .edge_addr(pf_hi));

  always_comb begin
    wins[WIN_IO]      = '{lo: io_lo,      hi: io_hi,      en: io_space_en,  io_space: 1'b1};
    wins[WIN_MEM]     = '{lo: mem_lo,     hi: mem_hi,     en: mem_space_en, io_space: 1'b0};
    wins[WIN_PF]      = '{lo: pf_lo,      hi: pf_hi,      en: mem_space_en, io_space: 1'b0};
    wins[WIN_LEG_MEM] = '{lo: LEG_MEM_LO, hi: LEG_MEM_HI, en: vga_en,       io_space: 1'b0};
    wins[WIN_LEG_IOA] = '{lo: LEG_IOA_LO, hi: LEG_IOA_HI, en: vga_en,       io_space: 1'b1};
    wins[WIN_LEG_IOB] = '{lo: LEG_IOB_LO, hi: LEG_IOB_HI, en: vga_en,       io_space: 1'b1};
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    bwd_range_match u_match (
      .win(wins[w]), .addr(req_addr), .is_io(req_is_io), .match(match[w])
    );
  end

  // next-state
  logic io_d, mem_d, pf_d, vga_d, fwd_d;
  always_comb begin
    io_d  = req_valid && match[WIN_IO];
    mem_d = req_valid && match[WIN_MEM];
    pf_d  = req_valid && match[WIN_PF];
    vga_d = req_valid && (match[WIN_LEG_MEM] || match[WIN_LEG_IOA] || match[WIN_LEG_IOB]);
    fwd_d = io_d || mem_d || pf_d || vga_d;
  end

  // registers, updated every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_valid <= 1'b0;
      hit_io    <= 1'b0;
      hit_mem   <= 1'b0;
      hit_pf    <= 1'b0;
      hit_vga   <= 1'b0;
      forward   <= 1'b0;
    end else begin
      hit_valid <= req_valid;
      hit_io    <= io_d;
      hit_mem   <= mem_d;
      hit_pf    <= pf_d;
      hit_vga   <= vga_d;
      forward   <= fwd_d;
    end
  end

  // assertion support: $past is meaningful only after one clock out of reset
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !$past(req_valid) |-> !forward && !hit_valid);

  // R7
  io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && hit_io |-> $past(io_space_en) && $past(req_is_io));

  // R4
  io_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && hit_io |-> $past(req_addr) <= 64'hFFFF_FFFF);

  // R7
  mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && (hit_mem || hit_pf) |-> $past(mem_space_en) && !$past(req_is_io));

  // R9
  vga_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && hit_vga |-> $past(vga_en));

  // R9
  vga_mem_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && hit_vga && !$past(req_is_io) |->
      $past(req_addr) >= 64'hA0000 && $past(req_addr) <= 64'hBFFFF);

  // R10
  fwd_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forward |-> (hit_io || hit_mem || hit_pf || hit_vga));
endmodule

// File: tb/test_bridge_window_decode.sv
`timescale 1ns/1ps
module test_bridge_window_decode;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_is_io;
  logic [63:0] req_addr;
  logic [7:0]  io_base, io_limit;
  logic [15:0] io_base_upper, io_limit_upper;
  logic [15:0] mem_base, mem_limit, pf_base, pf_limit;
  logic [31:0] pf_base_upper, pf_limit_upper;
  logic        io_space_en, mem_space_en, vga_en;
  logic        hit_valid, hit_io, hit_mem, hit_pf, hit_vga, forward;

  int vectors = 0;
  int errors  = 0;

  always #2 clk = ~clk;

  bridge_window_decode i_bridge_window_decode (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_io(req_is_io), .io_base(io_base), .io_limit(io_limit),
    .io_base_upper(io_base_upper), .io_limit_upper(io_limit_upper),
    .mem_base(mem_base), .mem_limit(mem_limit), .pf_base(pf_base),
    .pf_limit(pf_limit), .pf_base_upper(pf_base_upper),
    .pf_limit_upper(pf_limit_upper), .io_space_en(io_space_en),
    .mem_space_en(mem_space_en), .vga_en(vga_en), .hit_valid(hit_valid),
    .hit_io(hit_io), .hit_mem(hit_mem), .hit_pf(hit_pf), .hit_vga(hit_vga),
    .forward(forward)
  );

  // window edges computed arithmetically from the requirements
  logic [63:0] e_iob, e_iol, e_mb, e_ml, e_pb, e_pl;

  task automatic compute_edges();
    // R3, R4
    e_iob = 64'(io_base >> 4) * 64'd4096 + (io_base[0] ? 64'(io_base_upper) * 64'd65536 : 64'd0);
    e_iol = 64'(io_limit >> 4) * 64'd4096 + 64'd4095
          + (io_limit[0] ? 64'(io_limit_upper) * 64'd65536 : 64'd0);
    // R5
    e_mb = 64'(mem_base >> 4) * 64'd1048576;
    e_ml = 64'(mem_limit >> 4) * 64'd1048576 + 64'd1048575;
    // R6
    e_pb = 64'(pf_base >> 4) * 64'd1048576 + (pf_base[0] ? 64'(pf_base_upper) << 32 : 64'd0);
    e_pl = 64'(pf_limit >> 4) * 64'd1048576 + 64'd1048575
         + (pf_limit[0] ? 64'(pf_limit_upper) << 32 : 64'd0);
  endtask

  task automatic set_cfg(input int k);
    io_base        = {4'(k % 5 + 1), 3'(k >> 2), k[0]};
    io_limit       = {4'((k * 3) % 7 + 1), 3'(k), k[0] ^ k[5]};
    io_base_upper  = 16'(k % 3);
    io_limit_upper = 16'(k % 3 + int'(k[4]));
    mem_base       = {12'(k % 6 + 10), 4'(k)};
    mem_limit      = {12'((k * 5) % 9 + 8), 4'(k * 7)};
    pf_base        = {12'(k % 4 + 256), 3'(k), k[2]};
    pf_limit       = {12'((k * 7) % 5 + 256), 3'(k + 3), k[2] ^ k[5]};
    pf_base_upper  = 32'h2;
    pf_limit_upper = k[4] ? 32'h2 : 32'h3;
    io_space_en    = (k % 4 != 3);   // R7
    mem_space_en   = (k % 5 != 4);   // R7
    vga_en         = k[3];           // R9 with and without command enables
    compute_edges();
  endtask

  function automatic logic [63:0] pick_addr(input int j);
    case (j)
      0: return e_iob - 1;  1: return e_iob;  2: return e_iol;  3: return e_iol + 1;
      4: return e_mb - 1;   5: return e_mb;   6: return e_ml;   7: return e_ml + 1;
      8: return e_pb - 1;   9: return e_pb;   10: return e_pl;  11: return e_pl + 1;
      12: return 64'h9FFFF; 13: return 64'hA0000; 14: return 64'hBFFFF; 15: return 64'hC0000;
      16: return 64'h3AF;   17: return 64'h3B0;   18: return 64'h3BB;   19: return 64'h3BC;
      20: return 64'h3BF;   21: return 64'h3C0;   22: return 64'h3DF;   23: return 64'h3E0;
      24: return e_iob + 64'h800;
      25: return e_mb + 64'h1234;
      26: return e_pl - 5;
      default: return 64'h1_0000_03C0;
    endcase
  endfunction

  task automatic check(input logic [5:0] exp, input string why);
    logic [5:0] act;
    string tag;
    act = {hit_valid, hit_io, hit_mem, hit_pf, hit_vga, forward};
    vectors++;
    if (act !== exp) begin
      errors++;
      if (act[5] !== exp[5])      tag = "R2";
      else if (act[4] !== exp[4]) tag = "R3";
      else if (act[3] !== exp[3]) tag = "R5";
      else if (act[2] !== exp[2]) tag = "R6";
      else if (act[1] !== exp[1]) tag = "R9";
      else                        tag = "R10";
      $display("FAIL %s (%s) addr=%h io=%0b actual=%b expected=%b",
               tag, why, req_addr, req_is_io, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic io, input logic v);
    logic e_io, e_mem, e_pf, e_vga;
    req_addr = a; req_is_io = io; req_valid = v;
    // R8: empty windows fall out of the inclusive compares; R11: space gating
    e_io  = v && io && io_space_en && a >= e_iob && a <= e_iol;
    e_mem = v && !io && mem_space_en && a >= e_mb && a <= e_ml;
    e_pf  = v && !io && mem_space_en && a >= e_pb && a <= e_pl;
    e_vga = v && vga_en && ((!io && a >= 64'hA0000 && a <= 64'hBFFFF) ||
                            (io && a >= 64'h3B0 && a <= 64'h3BB) ||
                            (io && a >= 64'h3C0 && a <= 64'h3DF));
    @(negedge clk);
    check({v, e_io, e_mem, e_pf, e_vga, e_io | e_mem | e_pf | e_vga}, "sweep");
  endtask

  initial begin
    rst_n = 1'b0;
    set_cfg(8);
    req_valid = 1'b1; req_is_io = 1'b0; req_addr = 64'hA0000;
    repeat (3) @(negedge clk);
    check(6'b0, "R1 reset");   // R1
    rst_n = 1'b1;
    for (int k = 0; k < 48; k++) begin
      set_cfg(k);
      for (int j = 0; j < 28; j++) begin
        apply(pick_addr(j), 1'b0, 1'b1);
        apply(pick_addr(j), 1'b1, 1'b1);
      end
      apply(pick_addr(k % 28), k[0], 1'b0);   // R2 idle cycle
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule